// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block holds the pending-event register of a card-interface controller together with its software mask, and turns them into one level-sensitive interrupt line for the CPU. Neighbouring command and FIFO logic raise and retire individual events through per-bit set and clear strobes. Software writes the mask and reads back both the pending and the mask registers.

When the controller's command control word selects DMA mode, the two FIFO service events (receive ready and transmit ready) are withheld from the CPU interrupt. They are presented instead on two dedicated request lines to a DMA engine. Outside DMA mode those lines stay low, and the FIFO events reach the interrupt like any other source.

Top module: `irq_dma_router`

## Requirements
- R1: `irq` is high exactly when some pending bit is set whose mask bit is clear, after the DMA forcing of R3 has been applied.
- R2: A mask write keeps only bits 12:0 of `mask_wdata`. The upper bits of the write are ignored, and `mask_rd` shows the stored 13-bit value.
- R3: When `ctrl_word` bit 7 (DMA enable) is 1, pending bits 5 (receive FIFO) and 6 (transmit FIFO) are treated as masked for `irq`, whatever their mask bits hold.
- R4: With DMA enabled, `rx_dma_req` equals pending bit 5 and `tx_dma_req` equals pending bit 6.
- R5: With DMA disabled, `rx_dma_req` and `tx_dma_req` are both 0.
- R6: A 1 on a bit of `req_set` makes that pending bit 1 on the next clock edge. A 1 on a bit of `req_clr` makes it 0. Bits with neither strobe keep their value.
- R7: When set and clear strobe the same bit in the same cycle, the bit becomes 1.
- R8: `irq`, `rx_dma_req` and `tx_dma_req` are registered. They reflect the pending and mask registers one cycle after those registers change, and they reflect `ctrl_word` one cycle after it is applied.
- R9: Synchronous reset clears the pending register, the mask and all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 13 | Per-bit set strobes for the pending register |
| req_clr | input | 13 | Per-bit clear strobes for the pending register |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 32 | Mask write data; only bits 12:0 are kept |
| ctrl_word | input | 14 | Command control word; bit 7 enables DMA mode |
| irq | output | 1 | Level interrupt to the CPU |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| req_rd | output | 13 | Pending register readback |
| mask_rd | output | 13 | Mask register readback |

## Verification
A strobe or a mask write lands in its register on the first edge. The three outputs follow on the second edge, so the bench drives on the falling edge and samples readback after one rising edge and outputs after two. One check looks after only the first edge and confirms the interrupt still shows its previous value, which pins down the extra register stage. The sweep covers every single source with the mask set or clear and DMA on or off, plus pseudo-random multi-bit patterns, each compared against values computed by the bench.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int SRC_N      = 13;
  localparam int SRC_RXFIFO = 5;
  localparam int SRC_TXFIFO = 6;
  localparam int CTL_DMA_EN = 7;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // Per-bit update: a set strobe overrides a clear strobe on the same bit.
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           pend_q[i] <= 1'b0;
      else if (set_i[i]) pend_q[i] <= 1'b1;
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  p_set_lands_r6: assert property (@(posedge clk) disable iff (rst)
    |set_i |=> ((pend_o & $past(set_i)) == $past(set_i)));
  p_clear_lands_r6: assert property (@(posedge clk) disable iff (rst)
    |(clr_i & ~set_i) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
    ((set_i | clr_i) == '0) |=> $stable(pend_o));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N  = 13,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (we_i) mask_q <= wdata_i[N-1:0];
  end

  assign mask_o = mask_q;

  p_mask_keeps_low_r2: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (mask_o == $past(wdata_i[N-1:0])));
  p_mask_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_route_out.sv
module irq_route_out #(
  parameter int N     = 13,
  parameter int RX    = 5,
  parameter int TX    = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic         dma_en_i,
  output logic         irq_o,
  output logic         rx_dma_o,
  output logic         tx_dma_o
);
  logic [N-1:0] eff_mask;
  logic         irq_d;

  // In DMA mode the two FIFO service sources are removed from the interrupt.
  for (genvar i = 0; i < N; i++) begin : g_mask
    if (i == RX || i == TX) begin : g_fifo
      assign eff_mask[i] = mask_i[i] | dma_en_i;
    end else begin : g_plain
      assign eff_mask[i] = mask_i[i];
    end
  end

  assign irq_d = |(pend_i & ~eff_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o    <= 1'b0;
      rx_dma_o <= 1'b0;
      tx_dma_o <= 1'b0;
    end else begin
      irq_o    <= irq_d;
      rx_dma_o <= dma_en_i & pend_i[RX];
      tx_dma_o <= dma_en_i & pend_i[TX];
    end
  end

  p_irq_unmasked_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_i & ~mask_i) & ~(N'(1) << RX) & ~(N'(1) << TX)) != '0 |-> irq_o);
  p_fifo_hidden_r3: assert property (@(posedge clk) disable iff (rst)
    (dma_en_i && ((pend_i & ~mask_i) & ~(N'(1) << RX) & ~(N'(1) << TX)) == '0) |=> !irq_o);
  p_dma_follow_r4: assert property (@(posedge clk) disable iff (rst)
    dma_en_i |=> (rx_dma_o == $past(pend_i[RX]) && tx_dma_o == $past(pend_i[TX])));
  p_dma_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !dma_en_i |=> (!rx_dma_o && !tx_dma_o));
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_router_pkg::*;
#(
  parameter int NSRC    = SRC_N,
  parameter int WDATA_W = 32,
  parameter int CTRL_W  = 14,
  parameter int RX_BIT  = SRC_RXFIFO,
  parameter int TX_BIT  = SRC_TXFIFO,
  parameter int DMA_BIT = CTL_DMA_EN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    req_set,
  input  logic [NSRC-1:0]    req_clr,
  input  logic               mask_we,
  input  logic [WDATA_W-1:0] mask_wdata,
  input  logic [CTRL_W-1:0]  ctrl_word,
  output logic               irq,
  output logic               rx_dma_req,
  output logic               tx_dma_req,
  output logic [NSRC-1:0]    req_rd,
  output logic [NSRC-1:0]    mask_rd
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] mask;

  irq_req_bank #(.N(NSRC)) u_req (
    .clk(clk), .rst(rst), .set_i(req_set), .clr_i(req_clr), .pend_o(pend)
  );

  irq_mask_reg #(.N(NSRC), .DW(WDATA_W)) u_mask (
    .clk(clk), .rst(rst), .we_i(mask_we), .wdata_i(mask_wdata), .mask_o(mask)
  );

  irq_route_out #(.N(NSRC), .RX(RX_BIT), .TX(TX_BIT)) u_out (
    .clk(clk), .rst(rst), .pend_i(pend), .mask_i(mask),
    .dma_en_i(ctrl_word[DMA_BIT]),
    .irq_o(irq), .rx_dma_o(rx_dma_req), .tx_dma_o(tx_dma_req)
  );

  assign req_rd  = pend;
  assign mask_rd = mask;

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!irq && !rx_dma_req && !tx_dma_req && req_rd == '0 && mask_rd == '0));
endmodule

// File: tb/sim_irq_dma_router.sv
module sim_irq_dma_router;
  localparam int PERIOD = 10;
  localparam int N = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_set = '0, req_clr = '0;
  logic          mask_we = 1'b0;
  logic [31:0]   mask_wdata = '0;
  logic [13:0]   ctrl_word = '0;
  logic          irq, rx_dma_req, tx_dma_req;
  logic [N-1:0]  req_rd, mask_rd;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_dma_router u0 (
    .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .ctrl_word(ctrl_word),
    .irq(irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
    .req_rd(req_rd), .mask_rd(mask_rd)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // Replace pending with pat (clear all, set pat in one cycle), load mask, set DMA.
  task automatic apply(input logic [N-1:0] pat, input logic [N-1:0] m, input logic d);
    req_clr = '1; req_set = pat; mask_we = 1'b1; mask_wdata = {19'h0, m};
    ctrl_word = '0; ctrl_word[7] = d;
    @(negedge clk);
    req_clr = '0; req_set = '0; mask_we = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic exp_irq(input logic [N-1:0] p, input logic [N-1:0] m, input logic d);
    logic [N-1:0] em;
    em = m;
    if (d) begin em[5] = 1'b1; em[6] = 1'b1; end
    return |(p & ~em);
  endfunction

  task automatic check_all(input logic [N-1:0] p, input logic [N-1:0] m, input logic d);
    chk("R6 pending readback", 32'(req_rd), 32'(p));
    chk("R1/R3 irq", 32'(irq), 32'(exp_irq(p, m, d)));
    chk("R4/R5 rx dma", 32'(rx_dma_req), 32'(d & p[5]));
    chk("R4/R5 tx dma", 32'(tx_dma_req), 32'(d & p[6]));
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [N-1:0] p, m;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk("R9 irq", 32'(irq), 0);
    chk("R9 dma", 32'({rx_dma_req, tx_dma_req}), 0);
    chk("R9 pending", 32'(req_rd), 0);
    chk("R9 mask", 32'(mask_rd), 0);

    // R1 R3 R4 R5: every single source, masked or not, DMA on or off
    for (int b = 0; b < N; b++)
      for (int mm = 0; mm < 2; mm++)
        for (int d = 0; d < 2; d++) begin
          p = N'(1) << b;
          m = mm ? p : ~p;
          apply(p, m, d[0]);
          check_all(p, m, d[0]);
        end

    // Multi-bit pseudo-random patterns
    lfsr = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = lfsr[12:0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = lfsr[15:3];
      apply(p, m, lfsr[0]);
      check_all(p, m, lfsr[0]);
    end

    // R3: only FIFO sources pending and unmasked, DMA on -> no irq, both DMA lines high
    apply(13'h0060, 13'h0000, 1'b1);
    chk("R3 fifo hidden irq", 32'(irq), 0);
    chk("R4 both dma", 32'({rx_dma_req, tx_dma_req}), 2'b11);
    // R5: same with DMA off -> irq high, lines low
    apply(13'h0060, 13'h0000, 1'b0);
    chk("R5 fifo to irq", 32'(irq), 1);
    chk("R5 dma low", 32'({rx_dma_req, tx_dma_req}), 0);

    // R2: upper write bits ignored
    mask_we = 1'b1; mask_wdata = 32'hFFFF_E000 | 32'h0A5A;
    @(negedge clk);
    mask_we = 1'b0;
    chk("R2 mask truncated", 32'(mask_rd), 32'h0A5A);
    mask_we = 1'b1; mask_wdata = 32'hDEAD_0000;
    @(negedge clk);
    mask_we = 1'b0;
    chk("R2 upper only gives zero", 32'(mask_rd), 0);

    // R6: clear part, set part, idle holds
    apply(13'h1FFF, 13'h1FFF, 1'b0);
    req_clr = 13'h00F0;
    @(negedge clk);
    req_clr = '0;
    chk("R6 clear", 32'(req_rd), 32'h1F0F);
    @(negedge clk);
    chk("R6 hold", 32'(req_rd), 32'h1F0F);

    // R7: set and clear same bit
    req_clr = 13'h1FFF; req_set = 13'h0101;
    @(negedge clk);
    req_clr = '0; req_set = '0;
    chk("R7 set wins", 32'(req_rd), 32'h0101);

    // R8: latency - pending lands first edge, irq one edge later
    apply(13'h0000, 13'h0000, 1'b0);
    req_set = 13'h0004;
    @(negedge clk);
    req_set = '0;
    chk("R8 pending after one edge", 32'(req_rd), 32'h0004);
    chk("R8 irq not yet", 32'(irq), 0);
    @(negedge clk);
    chk("R8 irq after two edges", 32'(irq), 1);
    // R8: ctrl change visible after one edge
    req_clr = '1; req_set = 13'h0020;
    @(negedge clk);
    req_clr = '0; req_set = '0;
    @(negedge clk);
    ctrl_word[7] = 1'b1;
    chk("R8 ctrl before edge", 32'(rx_dma_req), 0);
    @(negedge clk);
    chk("R8 ctrl after edge", 32'(rx_dma_req), 1);
    chk("R8 ctrl irq", 32'(irq), 0);

    // R9: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset again", 32'({irq, rx_dma_req, tx_dma_req}), 0);
    chk("R9 pending again", 32'(req_rd), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule